// File: doc/BRIEF.md
# Word-to-Narrow-Port Access Splitter

This block connects a master that always moves whole 32-bit words to a slave port that is only 8 or 16 bits wide. Each master read or write is turned into a short run of slave transfers at consecutive slave word addresses. The slave's storage therefore shows up in the master's byte address space as one unbroken run of bytes. On a write, the master word is cut into slave-width slices. On a read, the returned slices are packed back into a single 32-bit word.

The master sees an ordinary single-word access. It holds its command, and the block keeps the master stalled until the last slave transfer has completed. The slave may stall any transfer with its own wait signal. When a read completes, the packed word comes back with a one-cycle valid pulse. The slave width is fixed at elaboration time.

Top module: `bus_narrower`

## Requirements
- R1: With `NARROW_W` = 16, a master access at byte address A produces exactly two slave transfers, at slave addresses A/2 and A/2+1, in that order.
- R2: With `NARROW_W` = 8, a master access at byte address A produces exactly four slave transfers, at slave addresses A, A+1, A+2 and A+3, in that order. Master byte lane k (bits 8k+7..8k) corresponds to slave address A+k.
- R3: A read returns on `m_rdata` the slave slices packed least significant first. The slice from transfer k lands in bits k·NARROW_W+NARROW_W−1 .. k·NARROW_W.
- R4: A write drives `s_wdata` on transfer k with bits k·NARROW_W+NARROW_W−1 .. k·NARROW_W of the master word, so the lowest slice goes out first.
- R5: `m_wait` is high in every cycle except the single cycle that follows acceptance of the final slave transfer. In that cycle `m_wait` is low and `s_read`/`s_write` are both low.
- R6: While `s_wait` is high during a slave transfer, the next cycle repeats the same `s_addr`, strobe and `s_wdata`, and the sequence does not advance.
- R7: `m_rvalid` is high for exactly one cycle per read, in the cycle where `m_wait` is low, and only when the final slave read beat was accepted on the previous edge. `m_rvalid` never rises for a write.
- R8: `NARROW_W` may be 8 or 16, which gives 32/`NARROW_W` slave transfers per master access. Any other value stops elaboration.
- R9: While and right after `rst` (synchronous, active high), `s_read`, `s_write` and `m_rvalid` are low and `m_wait` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | ADDR_W | Master byte address, word aligned |
| m_read | input | 1 | Master read command, held while `m_wait` is high |
| m_write | input | 1 | Master write command, held while `m_wait` is high |
| m_wdata | input | 32 | Master write word |
| m_wait | output | 1 | Stall to the master; low for one cycle when an access completes |
| m_rdata | output | 32 | Packed read word |
| m_rvalid | output | 1 | One-cycle pulse qualifying `m_rdata` |
| s_addr | output | ADDR_W | Slave word address of the current transfer |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | NARROW_W | Slave write slice |
| s_rdata | input | NARROW_W | Slave read slice, valid when `s_read` is high and `s_wait` is low |
| s_wait | input | 1 | Slave stall for the current transfer |

## Verification
Both legal widths run side by side against a byte-addressed slave model. Because the two models share the same byte contents, a correct packing gives the same read word at either width, while a swapped slice or a wrong address step gives different words. Accesses first run with the slave never stalling, which separates ordering and addressing faults from handshake faults. A later run has the slave stall pseudo-randomly, which shows whether a stalled beat is repeated unchanged and whether the release to the master waits for the final beat. Back-to-back mixed reads and writes, including the topmost word of the address space, show whether written data read back at contiguous offsets and whether a new command is taken cleanly right after a release.

// File: rtl/nw_pkg.sv
package nw_pkg;

    localparam int unsigned MWORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    function automatic int unsigned beats_of(input int unsigned nw);
        return MWORD_W / nw;
    endfunction

    function automatic int unsigned addr_shift_of(input int unsigned nw);
        return (nw == 16) ? 1 : 0;
    endfunction

    function automatic int unsigned idx_width_of(input int unsigned nw);
        return (beats_of(nw) > 2) ? $clog2(beats_of(nw)) : 1;
    endfunction

endpackage

// File: rtl/nw_seq.sv
module nw_seq
    import nw_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NW     = 16,
    localparam int unsigned BEATS  = beats_of(NW),
    localparam int unsigned BEAT_W = idx_width_of(NW),
    localparam int unsigned SHIFT  = addr_shift_of(NW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic              s_wait,
    output seq_state_e        state,
    output logic [BEAT_W-1:0] beat,
    output logic              is_wr,
    output logic              load,
    output logic              take,
    output logic [ADDR_W-1:0] s_addr,
    output logic              s_read,
    output logic              s_write
);

    seq_state_e        st_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] base_q;
    logic              wr_q;
    logic              last;

    assign last    = (beat_q == BEAT_W'(BEATS - 1));
    assign load    = (st_q == ST_IDLE) && (m_read || m_write);
    assign take    = (st_q == ST_RUN) && !s_wait;
    assign s_read  = (st_q == ST_RUN) && !wr_q;
    assign s_write = (st_q == ST_RUN) && wr_q;
    assign s_addr  = base_q + ADDR_W'(beat_q);
    assign state   = st_q;
    assign beat    = beat_q;
    assign is_wr   = wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (load) begin
                        base_q <= m_addr >> SHIFT;
                        wr_q   <= m_write;
                        beat_q <= '0;
                        st_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!s_wait) begin
                        if (last) st_q <= ST_DONE;
                        else      beat_q <= beat_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    beat_q <= '0;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_read || s_write) && s_wait |=> $stable(s_addr) && $stable(s_read) && $stable(s_write));

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        take && !last |=> (s_read || s_write) && (s_addr == $past(s_addr) + ADDR_W'(1)));

endmodule

// File: rtl/nw_wslice.sv
module nw_wslice
    import nw_pkg::*;
#(
    parameter int unsigned NW = 16,
    localparam int unsigned BEAT_W = idx_width_of(NW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MWORD_W-1:0] m_wdata,
    input  logic [BEAT_W-1:0] beat,
    output logic [NW-1:0]     s_wdata
);

    logic [MWORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= m_wdata;
    end

    assign s_wdata = word_q[int'(beat) * NW +: NW];

endmodule

// File: rtl/nw_rpack.sv
module nw_rpack
    import nw_pkg::*;
#(
    parameter int unsigned NW = 16,
    localparam int unsigned BEATS  = beats_of(NW),
    localparam int unsigned BEAT_W = idx_width_of(NW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [BEAT_W-1:0]  beat,
    input  logic [NW-1:0]      s_rdata,
    output logic [MWORD_W-1:0] word
);

    logic [MWORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (capture) begin
            for (int g = 0; g < BEATS; g++) begin
                if (beat == BEAT_W'(g)) word_q[g*NW +: NW] <= s_rdata;
            end
        end
    end

    assign word = word_q;

endmodule

// File: rtl/bus_narrower.sv
module bus_narrower
    import nw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic                m_read,
    input  logic                m_write,
    input  logic [31:0]         m_wdata,
    output logic                m_wait,
    output logic [31:0]         m_rdata,
    output logic                m_rvalid,
    output logic [ADDR_W-1:0]   s_addr,
    output logic                s_read,
    output logic                s_write,
    output logic [NARROW_W-1:0] s_wdata,
    input  logic [NARROW_W-1:0] s_rdata,
    input  logic                s_wait
);

    localparam int unsigned BEAT_W = idx_width_of(NARROW_W);

    // R8
    generate
        if (!(NARROW_W == 8 || NARROW_W == 16)) begin : g_bad_width
            $error("bus_narrower: NARROW_W must be 8 or 16");
        end
    endgenerate

    seq_state_e        state;
    logic [BEAT_W-1:0] beat;
    logic              is_wr;
    logic              load;
    logic              take;

    nw_seq #(.ADDR_W(ADDR_W), .NW(NARROW_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .m_addr (m_addr),
        .m_read (m_read),
        .m_write(m_write),
        .s_wait (s_wait),
        .state  (state),
        .beat   (beat),
        .is_wr  (is_wr),
        .load   (load),
        .take   (take),
        .s_addr (s_addr),
        .s_read (s_read),
        .s_write(s_write)
    );

    nw_wslice #(.NW(NARROW_W)) u_wslice (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .m_wdata(m_wdata),
        .beat   (beat),
        .s_wdata(s_wdata)
    );

    nw_rpack #(.NW(NARROW_W)) u_rpack (
        .clk    (clk),
        .rst    (rst),
        .capture(take && !is_wr),
        .beat   (beat),
        .s_rdata(s_rdata),
        .word   (m_rdata)
    );

    assign m_wait   = (state != ST_DONE);
    assign m_rvalid = (state == ST_DONE) && !is_wr;

    // R5
    release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !m_wait |-> !s_read && !s_write);

    // R7
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |=> !m_rvalid);

    // R7
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(m_rvalid) |-> $past(s_read && !s_wait));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_write && s_wait |=> s_write && $stable(s_wdata));

endmodule

// File: tb/test_bus_narrower.sv
module test_lane #(
    parameter int unsigned NW = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   checks,
    output int   errors
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NB    = NW / 8;
    localparam int BEATS = 32 / NW;

    logic [7:0]    m_addr;
    logic          m_read;
    logic          m_write;
    logic [31:0]   m_wdata;
    logic          m_wait;
    logic [31:0]   m_rdata;
    logic          m_rvalid;
    logic [7:0]    s_addr;
    logic          s_read;
    logic          s_write;
    logic [NW-1:0] s_wdata;
    logic [NW-1:0] s_rdata;
    logic          s_wait;

    bus_narrower #(.ADDR_W(8), .NARROW_W(NW)) i_bus_narrower (
        .clk     (clk),
        .rst     (rst),
        .m_addr  (m_addr),
        .m_read  (m_read),
        .m_write (m_write),
        .m_wdata (m_wdata),
        .m_wait  (m_wait),
        .m_rdata (m_rdata),
        .m_rvalid(m_rvalid),
        .s_addr  (s_addr),
        .s_read  (s_read),
        .s_write (s_write),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata),
        .s_wait  (s_wait)
    );

    // byte-addressed slave storage shared by both widths
    logic [7:0] mem [256];

    always_comb begin
        for (int b = 0; b < NB; b++) s_rdata[b*8 +: 8] = mem[8'(int'(s_addr) * NB + b)];
    end

    always @(posedge clk) begin
        if (s_write && !s_wait)
            for (int b = 0; b < NB; b++) mem[8'(int'(s_addr) * NB + b)] <= s_wdata[b*8 +: 8];
    end

    // reference model state
    logic [7:0]    q_addr [$];
    logic          q_wr   [$];
    logic [NW-1:0] q_dat  [$];
    bit            done_due;
    bit            cur_rd;
    logic [31:0]   exp_rd;
    bit            wait_mode;
    bit            seen_reset;
    bit            stalled_prev;
    logic [7:0]    lfsr;
    int            beat_cnt;
    string         addr_tag;

    initial begin
        addr_tag = (NW == 16) ? "R1" : "R2";
        checks = 0; errors = 0; done = 0;
        done_due = 0; cur_rd = 0; exp_rd = '0; wait_mode = 0;
        seen_reset = 0; stalled_prev = 0; lfsr = 8'h5B; beat_cnt = 0;
        s_wait = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (width %0d): got %h expected %h at %0t", req, NW, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            s_wait = 0;
        end else begin
            if (!seen_reset) begin
                seen_reset = 1;
                // R9
                chk(!s_read && !s_write, "R9", {30'd0, s_read, s_write}, 0);
                chk(!m_rvalid && m_wait, "R9", {30'd0, m_rvalid, m_wait}, 32'd1);
            end
            if (done_due) begin
                chk(m_wait == 1'b0, "R5", 32'(m_wait), 0);
                chk(m_rvalid == cur_rd, "R7", 32'(m_rvalid), 32'(cur_rd));
                if (cur_rd) chk(m_rdata == exp_rd, "R3", m_rdata, exp_rd);
                chk(beat_cnt == BEATS, "R8", beat_cnt, BEATS);
                beat_cnt = 0;
                done_due = 0;
            end else begin
                chk(m_wait == 1'b1, "R5", 32'(m_wait), 32'd1);
                chk(m_rvalid == 1'b0, "R7", 32'(m_rvalid), 0);
            end
            if (s_read || s_write) begin
                if (q_addr.size() == 0) begin
                    chk(0, addr_tag, {24'd0, s_addr}, 0);
                    s_wait = 0;
                end else begin
                    chk(s_addr == q_addr[0], stalled_prev ? "R6" : addr_tag, {24'd0, s_addr}, {24'd0, q_addr[0]});
                    chk(s_write == q_wr[0], stalled_prev ? "R6" : addr_tag, 32'(s_write), 32'(q_wr[0]));
                    if (s_write) chk(s_wdata == q_dat[0], "R4", 32'(s_wdata), 32'(q_dat[0]));
                    s_wait = wait_mode && lfsr[0];
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    stalled_prev = s_wait;
                    if (!s_wait) begin
                        void'(q_addr.pop_front());
                        void'(q_wr.pop_front());
                        void'(q_dat.pop_front());
                        beat_cnt++;
                        if (q_addr.size() == 0) done_due = 1;
                    end
                end
            end else begin
                s_wait = 0;
                stalled_prev = 0;
            end
        end
    end

    task automatic do_op(input bit wr, input logic [7:0] a, input logic [31:0] d);
        for (int k = 0; k < BEATS; k++) begin
            q_addr.push_back((NW == 16) ? 8'((a >> 1) + k) : 8'(a + k));
            q_wr.push_back(wr);
            q_dat.push_back(d[k*NW +: NW]);
        end
        cur_rd = !wr;
        if (!wr) exp_rd = {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[a]};
        m_addr  = a;
        m_read  = !wr;
        m_write = wr;
        m_wdata = d;
        do @(negedge clk); while (m_wait);
        @(posedge clk);
        #1;
        m_read  = 0;
        m_write = 0;
    endtask

    initial begin
        m_addr = 0; m_read = 0; m_write = 0; m_wdata = 0;
        @(negedge rst);
        @(posedge clk);
        #1;
        repeat (2) @(posedge clk);
        #1;
        // R1 R2 R3: reads without slave stalls
        do_op(0, 8'h00, 0);
        do_op(0, 8'h04, 0);
        do_op(0, 8'h10, 0);
        // R4: write then read back
        do_op(1, 8'h20, 32'hA1B2_C3D4);
        do_op(0, 8'h20, 0);
        // R6: slave stalls on
        wait_mode = 1;
        do_op(1, 8'h40, 32'h1234_5678);
        do_op(0, 8'h40, 0);
        do_op(0, 8'hFC, 0);
        for (int i = 0; i < 14; i++) begin
            do_op((i % 3) == 0, 8'(i * 20) & 8'hFC, 32'h9E37_79B9 * 32'(i + 1));
        end
        repeat (4) @(negedge clk);
        done = 1;
    end

endmodule

module test_bus_narrower;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 0;
    logic rst = 1;
    logic d16, d8;
    int   c16, c8, e16, e8;
    int   wd_fail = 0;

    always #2.5 clk = ~clk;

    test_lane #(.NW(16)) u_w16 (.clk(clk), .rst(rst), .done(d16), .checks(c16), .errors(e16));
    test_lane #(.NW(8))  u_w8  (.clk(clk), .rst(rst), .done(d8),  .checks(c8),  .errors(e8));

    initial begin
        int cyc = 0;
        rst = 1;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        while (!(d16 && d8) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d16 && d8)) begin
            wd_fail = 1;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", c16 + c8 + wd_fail, e16 + e8 + wd_fail);
        $finish;
    end

endmodule